// File: doc/BRIEF.md
# Dual-clock FIFO with programmable fill flags

The block is a first-in first-out buffer, 9 bits wide, whose depth is a power-of-two parameter from 256 to 8192. Words go in on one clock and come out on another, and the two clocks are unrelated. Four active-low status flags report the fill level. Full and almost-full belong to the write clock. Empty and almost-empty belong to the read clock. Each pointer crosses into the other domain as Gray code through a two-flop synchronizer. A flag therefore asserts on the edge of the operation that causes it, and releases a few cycles late once the far side has moved.

Two offsets set the flag thresholds. The empty offset n sets how far above empty the almost-empty flag releases. The full offset m sets how far below full the almost-full flag asserts. Both reset to 7. A small load port on the write clock can rewrite them, but only until the first accepted write after reset. A two-channel arrangement is built as two instances of this block.

Top module: `dcf_pflag_top`

## Requirements
- R1: After reset is released, and before any write, full_n_o=1, almost_full_n_o=1, almost_empty_n_o=0 and empty_n_o=0.
- R2: With 1 to n words stored, empty_n_o=1 and almost_empty_n_o=0, where n is the empty offset (7 after reset).
- R3: With n+1 or more words stored, almost_empty_n_o=1. If no read follows reset, it goes high after exactly n+1 writes.
- R4: almost_full_n_o=0 whenever the stored count is at least DEPTH-m, and 1 below that. If no read follows reset, it falls after exactly DEPTH-m writes, where m is the full offset (7 after reset).
- R5: With DEPTH words stored, full_n_o=0 and almost_full_n_o=0. With fewer than DEPTH words stored, full_n_o=1.
- R6: A write while full_n_o=0 is ignored and stores nothing. A read while empty_n_o=0 is ignored and moves no pointer.
- R7: When cfg_we_i=1 on a write-clock edge, cfg_data_i is loaded into the empty offset n if cfg_sel_i=0, or into the full offset m if cfg_sel_i=1.
- R8: An offset load is ignored once a write has been accepted since the last reset.
- R9: Words are read out in the order they were written, unchanged. A read accepted on a read-clock edge presents its word on rdata_o from that edge.
- R10: full_n_o and almost_full_n_o change on the write-clock edge of the write that fills the buffer to their threshold. empty_n_o and almost_empty_n_o change on the read-clock edge of the read that drains it to their threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| wr_en_i | input | 1 | Write request |
| wdata_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read request |
| rdata_o | output | DATA_W | Read data, registered |
| full_n_o | output | 1 | Full flag, active low, write clock |
| almost_full_n_o | output | 1 | Almost-full flag, active low, write clock |
| almost_empty_n_o | output | 1 | Almost-empty flag, active low, read clock |
| empty_n_o | output | 1 | Empty flag, active low, read clock |
| cfg_we_i | input | 1 | Offset load strobe, write clock |
| cfg_sel_i | input | 1 | 0 selects the empty offset, 1 selects the full offset |
| cfg_data_i | input | $clog2(DEPTH) | Offset value to load |

## Verification
A write pointer that slips or overruns shows up in the flag pattern at a known write count. Almost-full then falls one write early or late, or full never asserts on the write-clock edge of the DEPTH-th write. A bad read pointer, or a bad synchronized copy of the write pointer, shows up on the read side. The drained data word is wrong on the very edge of the read, or empty and almost-empty disagree with the table a few read cycles after the writes stop. Offset registers that take a late load, or that reset to the wrong value, move a flag threshold, and the flag changes on the wrong write.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int unsigned DATA_W  = 9;
  localparam int unsigned OFF_RST = 7;
  localparam logic        SEL_EMPTY = 1'b0;
  localparam logic        SEL_FULL  = 1'b1;
endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    bin_o[W-1] = s2_q[W-1];
    for (int i = W - 2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ s2_q[i];
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [PW-1:0] rptr_sync_i,
  input  logic          cfg_we_i,
  input  logic          cfg_sel_i,
  input  logic [AW-1:0] cfg_data_i,
  output logic          wr_fire_o,
  output logic [PW-1:0] wptr_o,
  output logic [PW-1:0] wptr_gray_o,
  output logic [AW-1:0] n_off_o,
  output logic          full_n_o,
  output logic          afull_n_o
);
  import dcf_pkg::*;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [PW-1:0] wptr_q, wptr_nxt, gray_q, lvl_nxt, afull_lim;
  logic [AW-1:0] n_off_q, m_off_q;
  logic          cfg_lock_q, full_n_q, afull_n_q;

  assign wr_fire_o = wr_en_i & full_n_q;
  assign wptr_nxt  = wptr_q + PW'(wr_fire_o);
  assign lvl_nxt   = wptr_nxt - rptr_sync_i;
  assign afull_lim = DEPTH_P - {1'b0, m_off_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q    <= '0;
      gray_q    <= '0;
      full_n_q  <= 1'b1;
      afull_n_q <= 1'b1;
    end else begin
      wptr_q    <= wptr_nxt;
      gray_q    <= wptr_nxt ^ (wptr_nxt >> 1);
      full_n_q  <= (lvl_nxt != DEPTH_P);
      afull_n_q <= (lvl_nxt < afull_lim);
    end
  end

  // offsets are frozen from the first accepted write until reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_off_q    <= AW'(OFF_RST);
      m_off_q    <= AW'(OFF_RST);
      cfg_lock_q <= 1'b0;
    end else begin
      if (wr_fire_o) cfg_lock_q <= 1'b1;
      if (cfg_we_i && !cfg_lock_q) begin
        if (cfg_sel_i == SEL_FULL) m_off_q <= cfg_data_i;
        else                       n_off_q <= cfg_data_i;
      end
    end
  end

  assign wptr_o      = wptr_q;
  assign wptr_gray_o = gray_q;
  assign n_off_o     = n_off_q;
  assign full_n_o    = full_n_q;
  assign afull_n_o   = afull_n_q;

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !full_n_q) |=> $stable(wptr_q));
  p_full_has_afull_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_n_q |-> !afull_n_q);
  p_cfg_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_lock_q |=> ($stable(m_off_q) && $stable(n_off_q)));
  p_gray_onebit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [PW-1:0] wptr_sync_i,
  input  logic [AW-1:0] n_off_i,
  output logic          rd_fire_o,
  output logic [PW-1:0] rptr_o,
  output logic [PW-1:0] rptr_gray_o,
  output logic          empty_n_o,
  output logic          aempty_n_o
);
  logic [PW-1:0] rptr_q, rptr_nxt, gray_q, lvl_nxt;
  logic          empty_n_q, aempty_n_q;

  assign rd_fire_o = rd_en_i & empty_n_q;
  assign rptr_nxt  = rptr_q + PW'(rd_fire_o);
  assign lvl_nxt   = wptr_sync_i - rptr_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q     <= '0;
      gray_q     <= '0;
      empty_n_q  <= 1'b0;
      aempty_n_q <= 1'b0;
    end else begin
      rptr_q     <= rptr_nxt;
      gray_q     <= rptr_nxt ^ (rptr_nxt >> 1);
      empty_n_q  <= (lvl_nxt != '0);
      aempty_n_q <= (lvl_nxt > {1'b0, n_off_i});
    end
  end

  assign rptr_o      = rptr_q;
  assign rptr_gray_o = gray_q;
  assign empty_n_o   = empty_n_q;
  assign aempty_n_o  = aempty_n_q;

  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !empty_n_q) |=> $stable(rptr_q));
  p_empty_has_aempty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_n_q |-> !aempty_n_q);
endmodule

// File: rtl/dcf_pflag_top.sv
module dcf_pflag_top #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = dcf_pkg::DATA_W,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PW    = AW + 1
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_n_o,
  output logic              almost_full_n_o,
  output logic              almost_empty_n_o,
  output logic              empty_n_o,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [AW-1:0]     cfg_data_i
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     wptr, wgray, rptr, rgray, wptr_rs, rptr_ws;
  logic [AW-1:0]     n_off;
  logic              wr_fire, rd_fire;
  logic [DATA_W-1:0] rdata_q;

  dcf_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .clk_i(wclk_i), .rst_ni, .wr_en_i, .rptr_sync_i(rptr_ws),
    .cfg_we_i, .cfg_sel_i, .cfg_data_i,
    .wr_fire_o(wr_fire), .wptr_o(wptr), .wptr_gray_o(wgray), .n_off_o(n_off),
    .full_n_o(full_n_o), .afull_n_o(almost_full_n_o)
  );

  dcf_rd_ctl #(.DEPTH(DEPTH)) u_rd (
    .clk_i(rclk_i), .rst_ni, .rd_en_i, .wptr_sync_i(wptr_rs),
    // n_off is quasi-static: only loadable before the first write
    .n_off_i(n_off),
    .rd_fire_o(rd_fire), .rptr_o(rptr), .rptr_gray_o(rgray),
    .empty_n_o(empty_n_o), .aempty_n_o(almost_empty_n_o)
  );

  dcf_gray_sync #(.W(PW)) u_w2r (
    .clk_i(rclk_i), .rst_ni, .gray_i(wgray), .bin_o(wptr_rs)
  );

  dcf_gray_sync #(.W(PW)) u_r2w (
    .clk_i(wclk_i), .rst_ni, .gray_i(rgray), .bin_o(rptr_ws)
  );

  always_ff @(posedge wclk_i) begin
    if (wr_fire) mem_q[wptr[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_fire) rdata_q <= mem_q[rptr[AW-1:0]];
  end

  assign rdata_o = rdata_q;
endmodule

// File: tb/dcf_pflag_top_tb_top.sv
module dcf_pflag_top_tb_top;
  localparam int DEPTH = 256;
  localparam int AW    = $clog2(DEPTH);

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, cfg_we = 0, cfg_sel = 0;
  logic [8:0] wdata = '0;
  logic [AW-1:0] cfg_data = '0;
  logic [8:0] rdata;
  logic full_n, afull_n, aempty_n, empty_n;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [8:0] exp_q [$];
  logic rd_hit = 0;

  always #5 wclk = ~wclk;
  initial begin #3; forever #5 rclk = ~rclk; end

  dcf_pflag_top #(.DEPTH(DEPTH)) dut_i (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata),
    .full_n_o(full_n), .almost_full_n_o(afull_n),
    .almost_empty_n_o(aempty_n), .empty_n_o(empty_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // flags as 4 bits {full_n, afull_n, aempty_n, empty_n}
  task automatic check_flags(input string tag, input logic [3:0] exp);
    check({full_n, afull_n, aempty_n, empty_n} == exp, tag,
          int'({full_n, afull_n, aempty_n, empty_n}), int'(exp));
  endtask

  task automatic do_reset();
    @(negedge wclk);
    rst_n = 0; wr_en = 0; rd_en = 0; cfg_we = 0;
    exp_q.delete();
    #20;
    @(negedge wclk); #1;
    rst_n = 1;
    repeat (2) @(negedge wclk);
  endtask

  // driver: pushes the expected item when the model has room
  task automatic push(input logic [8:0] d);
    @(negedge wclk);
    wr_en = 1; wdata = d;
    if (exp_q.size() < DEPTH) exp_q.push_back(d);
    @(negedge wclk);
    wr_en = 0;
  endtask

  task automatic fill_to(input int target);
    while (exp_q.size() < target) push(9'((exp_q.size() * 37 + 5) & 9'h1ff));
  endtask

  task automatic pop();
    @(negedge rclk); rd_en = 1;
    @(negedge rclk); rd_en = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (2) @(negedge wclk);
  endtask

  task automatic load(input logic sel, input logic [AW-1:0] v);
    @(negedge wclk); cfg_we = 1; cfg_sel = sel; cfg_data = v;
    @(negedge wclk); cfg_we = 0;
  endtask

  // monitor: compares each word read against the scoreboard
  always @(posedge rclk) rd_hit <= rd_en && empty_n;
  always @(negedge rclk) begin
    if (rd_hit) begin
      if (exp_q.size() == 0) check(0, "R6 read accepted while empty", 1, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check(rdata == e, "R9 read data order", int'(rdata), int'(e));
      end
    end
  end

  initial begin
    #2_000_000;
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    do_reset();
    check_flags("R1 reset flags", 4'b1100);

    push(9'h011); settle();
    check_flags("R2 one word stored", 4'b1101);
    fill_to(7); settle();
    check_flags("R2 n words stored", 4'b1101);
    fill_to(8); settle();
    check_flags("R3 n+1 words stored", 4'b1111);

    fill_to(DEPTH - 8);
    check_flags("R4 depth-m-1 words stored", 4'b1111);
    fill_to(DEPTH - 7);
    check(afull_n == 0, "R4 R10 almost-full on write edge at depth-m", int'(afull_n), 0);
    fill_to(DEPTH - 1);
    check(full_n == 1, "R5 not full at depth-1", int'(full_n), 1);
    fill_to(DEPTH);
    check_flags("R5 R10 full on write edge at depth", 4'b0011);
    push(9'h1aa);
    check(full_n == 0, "R6 full held after extra write", int'(full_n), 0);
    settle();

    while (exp_q.size() > 0) pop();
    check(empty_n == 0, "R10 empty on read edge of last word", int'(empty_n), 0);
    check(aempty_n == 0, "R2 almost-empty with nothing stored", int'(aempty_n), 0);
    pop();
    push(9'h055); settle();
    check_flags("R6 one word after ignored read", 4'b1101);
    pop();
    check(empty_n == 0, "R6 empty after single read", int'(empty_n), 0);
    settle();
    check(afull_n == 1 && full_n == 1, "R5 write flags released after drain",
          int'({full_n, afull_n}), 3);

    do_reset();
    load(1'b0, AW'(3));
    load(1'b1, AW'(20));
    fill_to(3); settle();
    check_flags("R7 n=3 with 3 words", 4'b1101);
    fill_to(4); settle();
    check_flags("R7 n=3 with 4 words", 4'b1111);
    fill_to(DEPTH - 21);
    check(afull_n == 1, "R7 m=20 below threshold", int'(afull_n), 1);
    fill_to(DEPTH - 20);
    check(afull_n == 0, "R7 m=20 at threshold", int'(afull_n), 0);

    do_reset();
    push(9'h0f0);
    load(1'b0, AW'(50));
    load(1'b1, AW'(100));
    fill_to(8); settle();
    check(aempty_n == 1, "R8 empty offset load after write ignored", int'(aempty_n), 1);
    fill_to(DEPTH - 100);
    check(afull_n == 1, "R8 full offset load after write ignored", int'(afull_n), 1);
    settle();
    while (exp_q.size() > 0) pop();
    check(empty_n == 0, "R9 drained", int'(empty_n), 0);

    finish_run();
  end
endmodule